// File: doc/BRIEF.md
# Card clock divider with stop

This block derives the clock for one card port from a reference clock. The division is 1/1, 1/2 or 1/4. The card clock can also be parked at a chosen logic level and released again. The reference clock runs at twice the card-input rate. So for division 1/N, each output level lasts N reference cycles and the duty cycle is 50% for every ratio. The output is driven straight from a flip-flop, so it cannot glitch.

A new ratio is adopted only on a falling edge of the output. At that moment all counter phases restart from zero. The high phase in progress therefore always completes at its old length. Stopping takes effect on the next output transition that lands on the requested level. Releasing restarts the count, so the first level after a release lasts a full half-period. A chip places one instance per card port, and each instance has its own ratio and stop inputs.

Top module: `card_clk_div`

## Requirements
- R1: While `rst_n` is low, `card_clk` is 0.
- R2: With `div_code` 2'b00, 2'b01 or 2'b10, every high phase and every low phase of `card_clk` lasts 1, 2 or 4 reference cycles respectively.
- R3: `div_code` 2'b11 is reserved. Presenting it leaves the ratio in use unchanged.
- R4: A change of `div_code` is adopted at the next falling edge of `card_clk`. The high phase in progress keeps its old length, and the low phase that follows has the new length.
- R5: With `stop_req` high and `stop_lvl` 0, the current high phase completes at full length, and `card_clk` then stays 0.
- R6: With `stop_req` high and `stop_lvl` 1, the current low phase completes at full length, and `card_clk` then stays 1.
- R7: While the clock is parked, changes on `stop_lvl` do not affect `card_clk`.
- R8: When `stop_req` falls while parked, `card_clk` holds its level for one reference cycle plus one full half-period before its first transition.
- R9: A `div_code` presented while parked is adopted at the release and governs the first half-period after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock (twice the card-input rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_code | input | 2 | Ratio code: 00 = 1/1, 01 = 1/2, 10 = 1/4, 11 = reserved |
| stop_req | input | 1 | Request to park the card clock |
| stop_lvl | input | 1 | Level at which the clock is parked |
| card_clk | output | 1 | Card clock, registered |

## Verification
All inputs are driven on the falling edge of the reference clock, and `card_clk` is sampled on that same falling edge. Each sample therefore shows the state left by the preceding rising edge, since the output sits one register after the counter. A ratio change is due at the first falling output edge after it is presented, so the bench measures the remaining high run and then the low run that follows. Parking is due at the first transition that lands on the requested level, and the bench then counts held samples up to a cap. A release is due one cycle plus one half-period later, so the bench counts the run that includes the sample on which `stop_req` fell.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  // Default log2 of the largest division ratio (1/4 -> 2).
  localparam int DEF_MAX_LOG2 = 2;

  // A ratio code is usable when it names a power of two not above the maximum.
  function automatic logic code_ok(input int code, input int max_log2);
    return (code <= max_log2);
  endfunction
endpackage

// File: rtl/cdiv_ratio_ctl.sv
module cdiv_ratio_ctl #(
  parameter int MAX_LOG2 = cdiv_pkg::DEF_MAX_LOG2,
  parameter int CODE_W   = 2,
  parameter int CNT_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CNT_W-1:0]  lim_o
);
  logic [CODE_W-1:0] act_q, act_d;
  logic              code_valid;

  assign code_valid = cdiv_pkg::code_ok(int'(code_i), MAX_LOG2);

  // next state: reserved codes keep the active ratio
  always_comb begin
    act_d = act_q;
    if (load_i && code_valid) act_d = code_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= act_d;
  end

  // terminal count = 2**act - 1, built as a thermometer
  always_comb begin
    lim_o = '0;
    for (int i = 0; i < CNT_W; i++) lim_o[i] = (i < int'(act_q));
  end

  AST_RSVD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !code_valid) |=> $stable(act_q)); // R3
endmodule

// File: rtl/cdiv_phase_cnt.sv
module cdiv_phase_cnt #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_lim;

  assign at_lim = (cnt_q == lim_i);
  assign tick_o = run_i && at_lim;

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i)     cnt_d = '0;
    else if (run_i)  cnt_d = at_lim ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim_i); // R2
endmodule

// File: rtl/cdiv_stop_ctl.sv
module cdiv_stop_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic lvl_now_i,
  input  logic stop_req_i,
  input  logic stop_lvl_i,
  output logic stopped_o,
  output logic resume_o
);
  logic stopped_q, stopped_d;
  logic enter;

  // park only on a transition that lands on the requested level
  assign enter    = tick_i && stop_req_i && ((~lvl_now_i) == stop_lvl_i);
  assign resume_o = stopped_q && !stop_req_i;
  assign stopped_o = stopped_q;

  always_comb begin
    stopped_d = stopped_q;
    if (enter)         stopped_d = 1'b1;
    else if (resume_o) stopped_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stopped_q <= 1'b0;
    else        stopped_q <= stopped_d;
  end

  AST_STOP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stopped_q) |-> (lvl_now_i == $past(stop_lvl_i))); // R5
endmodule

// File: rtl/card_clk_div.sv
module card_clk_div #(
  parameter  int MAX_LOG2 = cdiv_pkg::DEF_MAX_LOG2,
  localparam int CODE_W   = $clog2(MAX_LOG2 + 2),
  localparam int CNT_W    = (MAX_LOG2 < 1) ? 1 : MAX_LOG2
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] div_code,
  input  logic              stop_req,
  input  logic              stop_lvl,
  output logic              card_clk
);
  logic [CNT_W-1:0] lim;
  logic tick, stopped, resume, fall, load;
  logic clk_q, clk_d;

  assign fall = tick && clk_q;
  assign load = fall || resume;

  cdiv_ratio_ctl #(.MAX_LOG2(MAX_LOG2), .CODE_W(CODE_W), .CNT_W(CNT_W)) u_ratio (
    .clk(clk_ref), .rst_n(rst_n), .load_i(load), .code_i(div_code), .lim_o(lim));

  cdiv_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk_ref), .rst_n(rst_n), .run_i(!stopped), .clear_i(resume),
    .lim_i(lim), .tick_o(tick));

  cdiv_stop_ctl u_stop (
    .clk(clk_ref), .rst_n(rst_n), .tick_i(tick), .lvl_now_i(clk_q),
    .stop_req_i(stop_req), .stop_lvl_i(stop_lvl),
    .stopped_o(stopped), .resume_o(resume));

  always_comb begin
    clk_d = clk_q;
    if (tick) clk_d = ~clk_q;
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) clk_q <= 1'b0;
    else        clk_q <= clk_d;
  end

  assign card_clk = clk_q;

  AST_STOP_HOLD: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (stopped && stop_req) |=> $stable(clk_q)); // R7
  AST_RATIO_HOLD_HIGH: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (clk_q && $past(clk_q) && !$past(stopped)) |-> $stable(lim)); // R4
endmodule

// File: tb/card_clk_div_test.sv
module card_clk_div_test;
  localparam int CLK_PERIOD = 10;
  // vector: [6:5] ratio code, [3:0] expected half-period in reference cycles
  localparam logic [6:0] VEC [0:5] = '{
    {2'b00, 1'b0, 4'd1}, {2'b01, 1'b0, 4'd2}, {2'b10, 1'b0, 4'd4},
    {2'b01, 1'b0, 4'd2}, {2'b00, 1'b0, 4'd1}, {2'b10, 1'b0, 4'd4}};

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] div_code;
  logic stop_req, stop_lvl;
  logic card_clk;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  card_clk_div uut (.clk_ref(clk), .rst_n(rst_n), .div_code(div_code),
    .stop_req(stop_req), .stop_lvl(stop_lvl), .card_clk(card_clk));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // count samples at level lvl, starting with the current one, up to cap
  task automatic run_len(input logic lvl, input int cap, output int n);
    n = 0;
    while (card_clk === lvl && n < cap) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic sync_to(input logic lvl);
    for (int i = 0; i < 64 && card_clk !== ~lvl; i++) @(negedge clk);
    for (int i = 0; i < 64 && card_clk !== lvl; i++) @(negedge clk);
  endtask

  initial begin
    int h, l, h2;
    rst_n = 1'b0; div_code = 2'b00; stop_req = 1'b0; stop_lvl = 1'b0;
    repeat (3) @(negedge clk);
    check_eq("R1 low in reset", int'(card_clk), 0);
    rst_n = 1'b1;

    foreach (VEC[i]) begin
      div_code = VEC[i][6:5];
      repeat (20) @(negedge clk);
      sync_to(1'b1);
      run_len(1'b1, 64, h);
      run_len(1'b0, 64, l);
      check_eq("R2 high phase", h, int'(VEC[i][3:0]));
      check_eq("R2 low phase", l, int'(VEC[i][3:0]));
    end

    // R3: reserved code keeps 1/2
    div_code = 2'b01; repeat (20) @(negedge clk);
    div_code = 2'b11; repeat (20) @(negedge clk);
    sync_to(1'b1);
    run_len(1'b1, 64, h); run_len(1'b0, 64, l);
    check_eq("R3 high keeps ratio", h, 2);
    check_eq("R3 low keeps ratio", l, 2);

    // R4: 1/4 -> 1/1 presented on the first high sample
    div_code = 2'b10; repeat (20) @(negedge clk);
    sync_to(1'b1);
    div_code = 2'b00;
    run_len(1'b1, 64, h); run_len(1'b0, 64, l); run_len(1'b1, 64, h2);
    check_eq("R4 old high completes", h, 4);
    check_eq("R4 new low", l, 1);
    check_eq("R4 new high", h2, 1);

    // R5: park low at 1/2
    div_code = 2'b01; repeat (20) @(negedge clk);
    sync_to(1'b1);
    stop_lvl = 1'b0; stop_req = 1'b1;
    run_len(1'b1, 64, h); run_len(1'b0, 30, l);
    check_eq("R5 high completes", h, 2);
    check_eq("R5 held low", l, 30);

    // R9: ratio changed while parked, then release
    div_code = 2'b10; repeat (5) @(negedge clk);
    stop_req = 1'b0;
    run_len(1'b0, 64, l); run_len(1'b1, 64, h);
    check_eq("R9 first low after release", l, 5);
    check_eq("R9 first high after release", h, 4);

    // R6: park high at 1/2
    div_code = 2'b01; repeat (20) @(negedge clk);
    sync_to(1'b0);
    stop_lvl = 1'b1; stop_req = 1'b1;
    run_len(1'b0, 64, l); run_len(1'b1, 30, h);
    check_eq("R6 low completes", l, 2);
    check_eq("R6 held high", h, 30);

    // R7: level change while parked
    stop_lvl = 1'b0;
    run_len(1'b1, 20, h);
    check_eq("R7 level change ignored", h, 20);

    // R8: release at 1/2
    stop_req = 1'b0;
    run_len(1'b1, 64, h); run_len(1'b0, 64, l);
    check_eq("R8 run after release", h, 3);
    check_eq("R8 next low", l, 2);

    // R1: reset during a high phase
    sync_to(1'b1);
    rst_n = 1'b0;
    #1;
    check_eq("R1 async clear", int'(card_clk), 0);
    @(negedge clk);
    check_eq("R1 held low", int'(card_clk), 0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule